// File: doc/BRIEF.md
# Dual-Line Serial Audio Input Slot Merger

This block sits behind the two serial input data lines of a codec link, a primary line and a secondary line. Both lines are framed by one shared frame-sync signal. Each frame on a line is a 16-bit tag slot followed by twelve 20-bit data slots, shifted in MSB first, one bit per clock. The tag slot of each line carries a codec-ready flag and one valid tag for each of the twelve data slots.

The block captures both lines in parallel. At the end of every data slot it looks at the two lines' tags for that slot and forwards the slot word of the line that claims it. The result is one merged stream of slot words, each with its slot number and a one-cycle strobe. The system is set up so that no slot is claimed by both lines. If both lines do claim a slot, the primary line wins and a sticky error flag records the clash. The block also latches each line's ready flag once per frame, so that software can poll it before it starts data transfer.

Top module: `acm_dual_merge`

## Requirements
- R1: During and after reset, and until a frame supplies data, `slot_valid`, `ready_pri`, `ready_sec` and `collide_err` are all 0.
- R2: A clock in which `sync` is sampled high after being sampled low marks the frame start. The bit sampled in the next clock is frame bit 0. The frame is laid out MSB first as a 16-bit tag slot (bits 0..15) and then data slots 1..12 of 20 bits each, so slot k ends at frame bit 15+20k.
- R3: Frame bit 0 of each line is that line's codec-ready flag. It appears on `ready_pri` / `ready_sec` one clock after the last tag-slot bit and holds until the tag slot of the next frame ends.
- R4: Frame bits 1..12 of a line are its valid tags for slots 1..12 in that order (bit 1 tags slot 1). Frame bits 13..15 are ignored.
- R5: When only the primary line tags slot k valid, `slot_valid` is high for exactly one clock, starting one clock after the last bit of slot k. In that clock `slot_num` = k and `slot_data` holds the primary's 20 slot bits, with the first bit received in bit 19.
- R6: When only the secondary line tags slot k valid, the same strobe carries the secondary's slot word with `slot_num` = k.
- R7: A slot tagged valid on neither line produces no strobe.
- R8: When both lines tag slot k valid, the strobe carries the primary's word, and `collide_err` goes high one clock after the slot ends. It stays high until reset.
- R9: A new frame start in the middle of a frame restarts framing at bit 0, and slots of the cut-off frame that had not yet ended give no strobe. After slot 12 ends, no strobe occurs until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit sampled per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame sync shared by both lines |
| sdin_pri | input | 1 | Primary serial input line |
| sdin_sec | input | 1 | Secondary serial input line |
| ready_pri | output | 1 | Latched codec-ready flag of the primary line |
| ready_sec | output | 1 | Latched codec-ready flag of the secondary line |
| slot_valid | output | 1 | One-clock strobe for a merged slot word |
| slot_num | output | 4 | Slot number 1..12 of the strobed word |
| slot_data | output | 20 | Merged slot word, first received bit in bit 19 |
| collide_err | output | 1 | Sticky flag: a slot was tagged valid on both lines |

## Verification
Any slip in the bit or slot counters moves a strobe off its expected clock. It also shifts the bits of the slot words, and this is visible at the first valid slot of the very next frame. A tag captured from the wrong bit positions, or routed from the wrong line, shows up as a missing or extra strobe, or as a word taken from the wrong line, within the same frame. Errors in the ready latch or the collision flag appear one clock after the tag slot ends, or after the clashing slot ends, and they persist where they can be polled.

// File: rtl/acm_pkg.sv
package acm_pkg;

    localparam int TAG_W   = 16;
    localparam int SLOT_W  = 20;
    localparam int N_SLOTS = 12;
    localparam int N_LINES = 2;
    localparam int CNT_W   = $clog2(SLOT_W);
    localparam int IDX_W   = $clog2(N_SLOTS + 1);

    typedef struct packed {
        logic             bit_en;
        logic [IDX_W-1:0] idx;
        logic             tag_end;
        logic             data_end;
    } frame_pos_t;

    typedef struct packed {
        logic [N_SLOTS-1:0] tag;
        logic [SLOT_W-1:0]  word;
    } line_view_t;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  num;
        logic [SLOT_W-1:0] data;
    } slot_out_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PRI  = 2'd1,
        SRC_SEC  = 2'd2,
        SRC_BOTH = 2'd3
    } src_e;

    function automatic src_e pick_src(input logic vp, input logic vs);
        src_e s;
        case ({vp, vs})
            2'b10:   s = SRC_PRI;
            2'b01:   s = SRC_SEC;
            2'b11:   s = SRC_BOTH;
            default: s = SRC_NONE;
        endcase
        return s;
    endfunction

    function automatic logic tag_for(input logic [N_SLOTS-1:0] t,
                                     input logic [IDX_W-1:0] i);
        logic r;
        r = 1'b0;
        for (int j = 1; j <= N_SLOTS; j++) begin
            if (i == IDX_W'(j)) r = t[N_SLOTS-j];
        end
        return r;
    endfunction

endpackage

// File: rtl/acm_frame_timer.sv
module acm_frame_timer
    import acm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync,
    output frame_pos_t fp
);

    localparam logic [CNT_W-1:0] TAG_LAST  = CNT_W'(TAG_W - 1);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_W - 1);
    localparam logic [IDX_W-1:0] IDX_TOP   = IDX_W'(N_SLOTS);

    logic             sync_q;
    logic             active;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] pos;
    logic             rise;
    logic             last;

    assign rise = sync & ~sync_q;
    assign last = active && (pos == ((idx == '0) ? TAG_LAST : SLOT_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            active <= 1'b0;
            idx    <= '0;
            pos    <= '0;
        end else begin
            sync_q <= sync;
            if (rise) begin
                active <= 1'b1;
                idx    <= '0;
                pos    <= '0;
            end else if (active) begin
                if (last) begin
                    pos <= '0;
                    if (idx == IDX_TOP) active <= 1'b0;
                    else                idx    <= idx + 1'b1;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    assign fp.bit_en   = active;
    assign fp.idx      = idx;
    assign fp.tag_end  = last && (idx == '0);
    assign fp.data_end = last && (idx != '0);

    // R9: framing stops after the final data slot unless a new start arrives
    assert_frame_stop_R9: assert property (@(posedge clk) disable iff (rst)
        (fp.data_end && idx == IDX_TOP && !rise) |=> !fp.bit_en);

    // R2: a frame start always leads to the tag slot being walked first
    assert_restart_tag_R2: assert property (@(posedge clk) disable iff (rst)
        rise |=> (fp.bit_en && fp.idx == '0 && !fp.data_end));

endmodule

// File: rtl/acm_line_deser.sv
module acm_line_deser
    import acm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_pos_t fp,
    input  logic       sdin,
    output line_view_t view,
    output logic       ready
);

    logic [SLOT_W-2:0]  sr;
    logic [SLOT_W-1:0]  word_now;
    logic [N_SLOTS-1:0] tag;

    assign word_now = {sr, sdin};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            tag   <= '0;
            ready <= 1'b0;
        end else begin
            if (fp.bit_en) sr <= word_now[SLOT_W-2:0];
            if (fp.tag_end) begin
                ready <= word_now[TAG_W-1];
                tag   <= word_now[TAG_W-2 -: N_SLOTS];
            end
        end
    end

    assign view.tag  = tag;
    assign view.word = word_now;

    // R3: the ready flag only moves right after the tag slot closes
    assert_ready_update_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ready) |-> $past(fp.tag_end));

endmodule

// File: rtl/acm_slot_merge.sv
module acm_slot_merge
    import acm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_pos_t fp,
    input  line_view_t view_p,
    input  line_view_t view_s,
    output slot_out_t  so,
    output logic       collide
);

    logic vp;
    logic vs;
    src_e src;

    assign vp  = tag_for(view_p.tag, fp.idx);
    assign vs  = tag_for(view_s.tag, fp.idx);
    assign src = pick_src(vp, vs);

    always_ff @(posedge clk) begin
        if (rst) begin
            so      <= '0;
            collide <= 1'b0;
        end else begin
            so.valid <= 1'b0;
            if (fp.data_end) begin
                so.valid <= (src != SRC_NONE);
                so.num   <= fp.idx;
                case (src)
                    SRC_PRI, SRC_BOTH: so.data <= view_p.word;
                    SRC_SEC:           so.data <= view_s.word;
                    default:           so.data <= '0;
                endcase
                if (src == SRC_BOTH) collide <= 1'b1;
            end
        end
    end

    // R5: a merged strobe lasts one clock
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        so.valid |=> !so.valid);

    // R5: strobed slot numbers are data slots only
    assert_num_range_R5: assert property (@(posedge clk) disable iff (rst)
        so.valid |-> (so.num >= IDX_W'(1) && so.num <= IDX_W'(N_SLOTS)));

    // R8: the clash flag never clears outside reset
    assert_collide_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        collide |=> collide);

    // R8: the clash flag rises only at the close of a data slot
    assert_collide_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(collide) |-> ($past(fp.data_end) && so.valid));

endmodule

// File: rtl/acm_dual_merge.sv
module acm_dual_merge
    import acm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync,
    input  logic              sdin_pri,
    input  logic              sdin_sec,
    output logic              ready_pri,
    output logic              ready_sec,
    output logic              slot_valid,
    output logic [IDX_W-1:0]  slot_num,
    output logic [SLOT_W-1:0] slot_data,
    output logic              collide_err
);

    frame_pos_t         fp;
    line_view_t         views [N_LINES];
    logic [N_LINES-1:0] sdin_v;
    logic [N_LINES-1:0] ready_v;
    slot_out_t          so;

    assign sdin_v = {sdin_sec, sdin_pri};

    acm_frame_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .sync (sync),
        .fp   (fp)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        acm_line_deser u_deser (
            .clk   (clk),
            .rst   (rst),
            .fp    (fp),
            .sdin  (sdin_v[g]),
            .view  (views[g]),
            .ready (ready_v[g])
        );
    end

    acm_slot_merge u_merge (
        .clk     (clk),
        .rst     (rst),
        .fp      (fp),
        .view_p  (views[0]),
        .view_s  (views[1]),
        .so      (so),
        .collide (collide_err)
    );

    assign ready_pri  = ready_v[0];
    assign ready_sec  = ready_v[1];
    assign slot_valid = so.valid;
    assign slot_num   = so.num;
    assign slot_data  = so.data;

    // R1: nothing is strobed in the clock after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> (!slot_valid && !collide_err && !ready_pri && !ready_sec));

endmodule

// File: tb/test_acm_dual_merge.sv
`timescale 1ns/1ps
module test_acm_dual_merge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync = 1'b0;
    logic        sdin_pri = 1'b0;
    logic        sdin_sec = 1'b0;
    logic        ready_pri, ready_sec, slot_valid, collide_err;
    logic [3:0]  slot_num;
    logic [19:0] slot_data;

    always #10 clk = ~clk;

    acm_dual_merge i_acm_dual_merge (
        .clk(clk), .rst(rst), .sync(sync),
        .sdin_pri(sdin_pri), .sdin_sec(sdin_sec),
        .ready_pri(ready_pri), .ready_sec(ready_sec),
        .slot_valid(slot_valid), .slot_num(slot_num),
        .slot_data(slot_data), .collide_err(collide_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int cyc = 0;
    int start_cyc = 0;

    int          ng = 0;
    logic [3:0]  got_num [16];
    logic [19:0] got_data [16];
    int          got_cyc [16];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && slot_valid) begin
            if (ng < 16) begin
                got_num[ng]  = slot_num;
                got_data[ng] = slot_data;
                got_cyc[ng]  = cyc;
            end
            ng = ng + 1;
        end
    end

    // {collide expected after frame, ready_p, ready_s, tags_p[11:0], tags_s[11:0]}
    // tag bit 11 = slot 1 ... tag bit 0 = slot 12
    localparam int NV = 7;
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 12'hA50, 12'h50F},
        {1'b0, 1'b0, 1'b1, 12'h000, 12'hFFF},
        {1'b0, 1'b1, 1'b1, 12'hFFF, 12'h000},
        {1'b0, 1'b0, 1'b0, 12'h000, 12'h000},
        {1'b0, 1'b1, 1'b1, 12'h801, 12'h402},
        {1'b1, 1'b1, 1'b0, 12'h0F0, 12'h0F0},
        {1'b1, 1'b0, 1'b1, 12'h001, 12'h300}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] dat(input int line, input int slot, input int seed);
        logic [19:0] v;
        v = 20'(seed * 32'h3A5 + slot * 32'h1111 + line * 32'h8421 + 32'h5);
        return v ^ {4'(slot), 16'h0};
    endfunction

    function automatic logic fbit(input logic r, input logic [11:0] t,
                                  input int line, input int seed, input int b);
        logic [15:0] w16;
        logic [19:0] w;
        int k, p;
        if (b < 16) begin
            w16 = {r, t, 3'b101};
            return w16[15-b];
        end
        k = (b - 16) / 20 + 1;
        p = (b - 16) % 20;
        w = dat(line, k, seed);
        return w[19-p];
    endfunction

    task automatic send_frame(input logic rp, input logic rs,
                              input logic [11:0] tp, input logic [11:0] ts,
                              input int seed, input int nbits, input int idle);
        @(negedge clk);
        sync = 1'b1; sdin_pri = 1'b0; sdin_sec = 1'b0;
        start_cyc = cyc;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            sync = (b < 15);
            sdin_pri = fbit(rp, tp, 0, seed, b);
            sdin_sec = fbit(rs, ts, 1, seed, b);
        end
        if (idle > 0) begin
            @(negedge clk);
            sync = 1'b0; sdin_pri = 1'b0; sdin_sec = 1'b0;
            repeat (idle) @(negedge clk);
        end
    endtask

    task automatic check_frame(input logic [11:0] tp, input logic [11:0] ts,
                               input int seed, input string tag);
        int e = 0;
        for (int k = 1; k <= 12; k++) begin
            logic vp, vs;
            string rq;
            logic [19:0] ed;
            vp = tp[12-k];
            vs = ts[12-k];
            if (vp || vs) begin
                rq = vp ? (vs ? "R8" : "R5") : "R6";
                ed = vp ? dat(0, k, seed) : dat(1, k, seed);
                if (e < ng && e < 16) begin
                    check(got_num[e] == 4'(k), {rq, " slot number ", tag}, 32'(got_num[e]), k);
                    check(got_data[e] == ed, {rq, " R4 slot data ", tag}, 32'(got_data[e]), 32'(ed));
                    check(got_cyc[e] - start_cyc == 17 + 20 * k, {"R2 strobe timing ", tag},
                          got_cyc[e] - start_cyc, 17 + 20 * k);
                end
                e++;
            end
        end
        check(ng == e, {"R7 strobe count ", tag}, ng, e);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!slot_valid && !ready_pri && !ready_sec && !collide_err,
              "R1 reset state", {ready_pri, ready_sec, slot_valid, collide_err}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!slot_valid && !ready_pri && !ready_sec && !collide_err,
              "R1 idle after reset", {ready_pri, ready_sec, slot_valid, collide_err}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            ng = 0;
            send_frame(v[25], v[24], v[23:12], v[11:0], i + 1, 256, 4);
            check_frame(v[23:12], v[11:0], i + 1, $sformatf("vec%0d", i));
            check(ready_pri == v[25], "R3 primary ready", ready_pri, v[25]);
            check(ready_sec == v[24], "R3 secondary ready", ready_sec, v[24]);
            check(collide_err == v[26], "R8 collide flag", collide_err, v[26]);
        end

        // R9: nothing after the last slot until the next start, despite line activity
        ng = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            sdin_pri = c[0]; sdin_sec = ~c[1];
        end
        check(ng == 0, "R9 no strobe between frames", ng, 0);

        // R9: restart in the middle of a frame
        ng = 0;
        send_frame(1'b1, 1'b0, 12'hA00, 12'h000, 20, 60, 0);
        check(ng == 1, "R9 cut frame strobe count", ng, 1);
        if (ng >= 1) check(got_num[0] == 4'd1, "R9 cut frame slot", 32'(got_num[0]), 1);
        ng = 0;
        send_frame(1'b0, 1'b1, 12'h010, 12'h200, 21, 256, 4);
        check_frame(12'h010, 12'h200, 21, "restart");
        check(ready_pri == 1'b0 && ready_sec == 1'b1, "R3 ready after restart",
              {ready_pri, ready_sec}, 2'b01);

        // R1 / R8: reset clears the sticky flag and ready state
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!collide_err && !ready_pri && !ready_sec && !slot_valid,
              "R1 R8 cleared by reset", {ready_pri, ready_sec, slot_valid, collide_err}, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule